// File: doc/BRIEF.md
# Trimmed One-Second Prescaler with Calibration Output

This block divides a crystal oscillator clock, nominally 32.768 kHz, down to a one-cycle seconds tick. A six-bit signed trim code changes how many oscillator cycles make up a second. A crystal that runs fast or slow can then be pulled back in fixed ppm steps. Trim is applied over a window of 15 seconds. In each window the first N seconds are lengthened by one cycle or shortened by two cycles, where N is the code's magnitude. Every other second in the window keeps the nominal length.

The block also drives the output-enable of a shared open-drain pin. When the calibration enable is set, the pin carries a square wave taken from a divider that is never trimmed. At the default sizes this wave is 512 Hz, so a frequency counter on the pin sees the raw crystal error. When calibration is off, the pin shows a static level chosen by a level bit. The pin is never driven high. Output-enable 1 pulls it low, and output-enable 0 releases it to the external pull-up.

The trim code is captured when a window starts. The code present while reset is asserted applies to the first window after reset.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: `tick_o` is high for exactly one clock cycle per second. The number of cycles from reset release to the first tick, and from each tick to the next, equals that second's length.
- R2: With a trim magnitude (bits 3:0) of zero, every second lasts CYC_PER_SEC cycles, whatever the sign bit (bit 5) is.
- R3: With sign bit 5 at 0 and magnitude N, the first N seconds of each 15-second window last CYC_PER_SEC+1 cycles. The rest last CYC_PER_SEC.
- R4: With sign bit 5 at 1 and magnitude N, the first N seconds of each window last CYC_PER_SEC-2 cycles. The rest last CYC_PER_SEC.
- R5: Trim bit 4 is reserved and has no effect on any second length.
- R6: The trim code is sampled at the start of each window, and during reset for the first window. A change made inside a window takes effect only from the next window.
- R7: With `ft_en_i` at 0, `pin_oe_o` equals the inverse of `out_lvl_i`, one clock later.
- R8: With `ft_en_i` at 1, `pin_oe_o` is a square wave with a period of REF_DIV cycles and 50% duty. It does not depend on `out_lvl_i` or on the trim code.
- R9: A synchronous reset releases the pin (`pin_oe_o` = 0), clears `tick_o` and restarts the 15-second window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| trim_i | input | MAG_W+2 | Trim code: bit 5 sign, bit 4 reserved, bits 3:0 magnitude |
| ft_en_i | input | 1 | Calibration square wave enable |
| out_lvl_i | input | 1 | Static pin level when calibration is off |
| tick_o | output | 1 | One-cycle seconds pulse |
| pin_oe_o | output | 1 | Open-drain enable: 1 pulls the pin low |

## Verification
On every cycle, the assertions check four things: the second counter stays below the current second length, the tick never lasts two cycles, a latched trim code holds still except at a window boundary, and the second length takes only one of its three legal values. Only the bench's scenarios can show that the right seconds in a window carry the adjustment and that the window totals match the ppm arithmetic. The same applies to the mid-window code change, the restart of the window on reset, and the exact period and duty of the calibration wave. The bench sweeps all 64 trim codes over a full window on a reduced second length.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;

  // Direction of the trim correction, taken from the sign bit of the code.
  typedef enum logic {
    TRIM_SLOW = 1'b0,  // negative correction: seconds are stretched
    TRIM_FAST = 1'b1   // positive correction: seconds are shortened
  } trim_dir_e;

  // Cycles added to one stretched second, and removed from one shortened second.
  localparam int STRETCH_CYC = 1;
  localparam int SHRINK_CYC  = 2;

endpackage

// File: rtl/rtcp_trim_sched.sv
module rtcp_trim_sched
  import rtcp_pkg::*;
#(
  parameter int CYC_PER_SEC = 32768,
  parameter int MAG_W       = 4,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  trim_dir_e        trim_dir_i,
  input  logic [MAG_W-1:0] trim_mag_i,
  input  logic             sec_end_i,
  output logic [CNT_W-1:0] sec_len_o
);

  localparam int              WIN_SECS = (1 << MAG_W) - 1;
  localparam logic [MAG_W-1:0] IDX_LAST = MAG_W'(WIN_SECS - 1);
  localparam logic [CNT_W-1:0] LEN_NOM  = CNT_W'(CYC_PER_SEC);
  localparam logic [CNT_W-1:0] LEN_LONG = CNT_W'(CYC_PER_SEC + STRETCH_CYC);
  localparam logic [CNT_W-1:0] LEN_SHRT = CNT_W'(CYC_PER_SEC - SHRINK_CYC);

  logic [MAG_W-1:0] sec_idx;
  logic [MAG_W-1:0] mag_q;
  trim_dir_e        dir_q;
  logic [CNT_W-1:0] len_next;

  // The window position advances once per second. The code is latched at each wrap.
  always_ff @(posedge clk) begin
    if (rst) begin
      sec_idx <= '0;
      mag_q   <= trim_mag_i;
      dir_q   <= trim_dir_i;
    end else if (sec_end_i) begin
      if (sec_idx == IDX_LAST) begin
        sec_idx <= '0;
        mag_q   <= trim_mag_i;
        dir_q   <= trim_dir_i;
      end else begin
        sec_idx <= sec_idx + 1'b1;
      end
    end
  end

  always_comb begin
    len_next = LEN_NOM;
    if (sec_idx < mag_q)
      len_next = (dir_q == TRIM_FAST) ? LEN_SHRT : LEN_LONG;
  end

  // Registered length: it is consumed only near the end of a second.
  always_ff @(posedge clk) begin
    if (rst) sec_len_o <= LEN_NOM;
    else     sec_len_o <= len_next;
  end

  a_r6_code_hold: assert property (@(posedge clk) disable iff (rst)
    (sec_idx != '0) |-> ($stable(mag_q) && $stable(dir_q)));

  a_r3_len_legal: assert property (@(posedge clk) disable iff (rst)
    (sec_len_o == LEN_NOM) || (sec_len_o == LEN_LONG) || (sec_len_o == LEN_SHRT));

  a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
    sec_idx <= IDX_LAST);

endmodule

// File: rtl/rtcp_sec_div.sv
module rtcp_sec_div #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] sec_len_i,
  output logic             sec_end_o,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt;

  assign sec_end_o = (cnt == sec_len_i - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (sec_end_o) begin
      cnt    <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt    <= cnt + 1'b1;
      tick_o <= 1'b0;
    end
  end

  a_r2_cnt_below_len: assert property (@(posedge clk) disable iff (rst)
    cnt < sec_len_i);

  a_r1_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

endmodule

// File: rtl/rtcp_ref_div.sv
module rtcp_ref_div #(
  parameter int REF_DIV = 64
) (
  input  logic clk,
  input  logic rst,
  output logic ref_o
);

  localparam int REF_W = $clog2(REF_DIV);

  logic [REF_W-1:0] ctr;

  // Free-running and never trimmed: the square wave period is exactly REF_DIV.
  always_ff @(posedge clk) begin
    if (rst) ctr <= '0;
    else     ctr <= ctr + 1'b1;
  end

  assign ref_o = ctr[REF_W-1];

endmodule

// File: rtl/rtcp_pin_drv.sv
module rtcp_pin_drv (
  input  logic clk,
  input  logic rst,
  input  logic ft_en_i,
  input  logic out_lvl_i,
  input  logic ref_i,
  output logic pin_oe_o
);

  logic level;

  // The calibration wave takes precedence over the static level.
  assign level = ft_en_i ? ref_i : out_lvl_i;

  // Open drain: enable the pull-down whenever the wanted level is low.
  always_ff @(posedge clk) begin
    if (rst) pin_oe_o <= 1'b0;
    else     pin_oe_o <= ~level;
  end

  a_r7_static_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !ft_en_i && !$past(ft_en_i) && $stable(out_lvl_i))
      |=> $stable(pin_oe_o));

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtcp_pkg::*;
#(
  parameter int CYC_PER_SEC = 32768,
  parameter int MAG_W       = 4,
  parameter int REF_DIV     = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MAG_W+1:0] trim_i,
  input  logic             ft_en_i,
  input  logic             out_lvl_i,
  output logic             tick_o,
  output logic             pin_oe_o
);

  localparam int CNT_W = $clog2(CYC_PER_SEC + 2);

  logic [CNT_W-1:0] sec_len;
  logic             sec_end;
  logic             ref_wave;
  logic             unused_rsvd_bit;

  assign unused_rsvd_bit = trim_i[MAG_W];

  rtcp_trim_sched #(
    .CYC_PER_SEC (CYC_PER_SEC),
    .MAG_W       (MAG_W),
    .CNT_W       (CNT_W)
  ) u_sched (
    .clk        (clk),
    .rst        (rst),
    .trim_dir_i (trim_dir_e'(trim_i[MAG_W+1])),
    .trim_mag_i (trim_i[MAG_W-1:0]),
    .sec_end_i  (sec_end),
    .sec_len_o  (sec_len)
  );

  rtcp_sec_div #(
    .CNT_W (CNT_W)
  ) u_div (
    .clk       (clk),
    .rst       (rst),
    .sec_len_i (sec_len),
    .sec_end_o (sec_end),
    .tick_o    (tick_o)
  );

  rtcp_ref_div #(
    .REF_DIV (REF_DIV)
  ) u_ref (
    .clk   (clk),
    .rst   (rst),
    .ref_o (ref_wave)
  );

  rtcp_pin_drv u_pin (
    .clk       (clk),
    .rst       (rst),
    .ft_en_i   (ft_en_i),
    .out_lvl_i (out_lvl_i),
    .ref_i     (ref_wave),
    .pin_oe_o  (pin_oe_o)
  );

endmodule

// File: tb/rtc_trim_prescaler_tb.sv
module rtc_trim_prescaler_tb;

  localparam int CYC     = 64;
  localparam int MAG_W   = 4;
  localparam int REF_DIV = 8;
  localparam int WIN     = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] trim = '0;
  logic       ft = 1'b0;
  logic       outl = 1'b0;
  logic       tick;
  logic       oe;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  rtc_trim_prescaler #(
    .CYC_PER_SEC (CYC),
    .MAG_W       (MAG_W),
    .REF_DIV     (REF_DIV)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .trim_i    (trim),
    .ft_en_i   (ft),
    .out_lvl_i (outl),
    .tick_o    (tick),
    .pin_oe_o  (oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [5:0] c, input int k);
    int m = int'(c[3:0]);
    if (k < m) return c[5] ? CYC - 2 : CYC + 1;
    return CYC;
  endfunction

  function automatic int exp_win(input logic [5:0] c);
    int m = int'(c[3:0]);
    return c[5] ? WIN * CYC - 2 * m : WIN * CYC + m;
  endfunction

  // Returns on the falling edge right after the reset-release edge is set up.
  task automatic do_reset(input logic [5:0] c);
    @(negedge clk);
    rst  = 1'b1;
    trim = c;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 4 * CYC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int sum;
    logic [5:0] ca;
    logic [5:0] cb;
    logic smp [32];
    int highs;

    // R9: reset state, with inputs that would otherwise pull the pin low
    ft = 1'b0;
    outl = 1'b0;
    repeat (3) @(negedge clk);
    chk(oe == 1'b0, "R9 pin released in reset", int'(oe), 0);
    chk(tick == 1'b0, "R9 tick low in reset", int'(tick), 0);

    // R1: the tick lasts one cycle
    do_reset(6'd0);
    wait_tick(n);
    chk(n == CYC, "R1 first interval", n, CYC);
    @(negedge clk);
    chk(tick == 1'b0, "R1 tick one cycle", int'(tick), 0);

    // Sweep all codes over one window: R2, R3, R4, R5
    for (int c = 0; c < 64; c++) begin
      string req;
      ca = 6'(c);
      if (ca[4])            req = "R5";
      else if (ca[3:0] == 0) req = "R2";
      else if (ca[5])        req = "R4";
      else                   req = "R3";
      do_reset(ca);
      sum = 0;
      for (int k = 0; k < WIN; k++) begin
        wait_tick(n);
        sum += n;
        chk(n == exp_len(ca, k), req, n, exp_len(ca, k));
      end
      chk(sum == exp_win(ca), req, sum, exp_win(ca));
    end

    // R6: a code change inside a window waits for the next window
    ca = 6'b000101;
    cb = 6'b100111;
    do_reset(ca);
    for (int k = 0; k < 3; k++) wait_tick(n);
    trim = cb;
    for (int k = 3; k < WIN; k++) begin
      wait_tick(n);
      chk(n == exp_len(ca, k), "R6 old code kept", n, exp_len(ca, k));
    end
    for (int k = 0; k < WIN; k++) begin
      wait_tick(n);
      chk(n == exp_len(cb, k), "R6 new code applied", n, exp_len(cb, k));
    end

    // R9: reset restarts the window (second 5 would be nominal without restart)
    do_reset(6'b000011);
    for (int k = 0; k < 5; k++) wait_tick(n);
    do_reset(6'b000011);
    wait_tick(n);
    chk(n == CYC + 1, "R9 window restart", n, CYC + 1);

    // R7: static level with calibration off
    @(negedge clk);
    ft = 1'b0;
    outl = 1'b0;
    @(negedge clk);
    chk(oe == 1'b1, "R7 level low", int'(oe), 1);
    outl = 1'b1;
    @(negedge clk);
    chk(oe == 1'b0, "R7 level high", int'(oe), 0);
    outl = 1'b0;
    @(negedge clk);
    chk(oe == 1'b1, "R7 level low again", int'(oe), 1);

    // R8: calibration wave, independent of the level bit and of the trim code
    trim = 6'b101111;
    for (int o = 0; o < 2; o++) begin
      outl = o[0];
      ft = 1'b1;
      repeat (2) @(negedge clk);
      highs = 0;
      for (int i = 0; i < 32; i++) begin
        smp[i] = oe;
        if (oe) highs++;
        @(negedge clk);
      end
      for (int i = REF_DIV / 2; i < 32; i++)
        chk(smp[i] != smp[i - REF_DIV / 2], "R8 half period", int'(smp[i]),
            int'(!smp[i - REF_DIV / 2]));
      chk(highs == 16, "R8 duty", highs, 16);
    end
    ft = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule